// File: doc/BRIEF.md
# NAND Page Buffer Column Pointer

This block tracks which byte of a 528-byte page buffer the next data transfer touches. The buffer has a 512-byte main part and a 16-byte spare part at columns 512 to 527. A controller upstream decodes the flash bus and feeds the block single-cycle pulses on one synchronous clock: a latched command byte, a latched address byte, or a read or write data strobe. The block returns the current column, a flag that is high while that column lies in the spare part, the active region code and a one-cycle page-advance pulse.

Three region commands pick the start of the pointer. 00h points at the lower half (base 0). 01h points at the upper half (base 256), which supplies the ninth column bit that no address cycle carries. 50h points at the spare part (base 512), but only while the spare-disable input is low. The first address byte after a region command is added to the base as an offset. Each data strobe then moves the column up by one. The upper-half choice lasts for one access only: the first strobe taken in that region sets the region back to the lower half. The lower-half and spare choices stay in force. Past column 527 the pointer wraps to the base of the region then in force and reports a page advance. Reset command FFh brings the pointer home.

The control is a four-state machine. The states are `ST_IDLE` (no access set up), `ST_COL` (waiting for the column byte), `ST_ROW` (column taken, further address bytes ignored) and `ST_STREAM` (data strobes flowing). The transitions are as follows. Any region command moves every state to `ST_COL`. An address byte moves `ST_COL` to `ST_ROW`. A data strobe moves `ST_COL`, `ST_ROW` or `ST_STREAM` to `ST_STREAM`. FFh moves every state to `ST_IDLE`. When several pulses arrive in one cycle, a command wins over an address byte, and an address byte wins over a strobe. Every output changes on the clock edge that samples the pulse.

Top module: `nand_colptr`

## Requirements
- R1: After rst_n is released, col_o is 0, region_o is 0 (lower half), spare_o is 0 and page_adv_o is 0.
- R2: Command 00h sets region_o to 0 and col_o to 0.
- R3: Command 01h sets region_o to 1 (upper half) and col_o to 256.
- R4: Command 50h with spare_dis_i low sets region_o to 2 (spare) and col_o to 512. While region_o is 2, col_o stays within 512..527.
- R5: Command 50h with spare_dis_i high changes neither col_o nor region_o.
- R6: The first address byte after a region command sets col_o. In region 0 the value is the byte. In region 1 it is 256 plus the byte. In region 2 it is 512 plus bits [3:0] of the byte.
- R7: Address bytes after that first one are ignored. So are address bytes that arrive when no region command has been given since the last FFh or reset.
- R8: Once a region command has been given, each cycle with rd_stb_i or wr_stb_i high raises col_o by one. Strobes in the idle state (after reset or FFh) leave col_o unchanged. col_o never exceeds 527.
- R9: A strobe taken while region_o is 1 sets region_o to 0 on the same edge that advances the column.
- R10: A strobe at column 527 loads col_o with the base of the region in force (0 for regions 0 and 1, 512 for region 2) and raises page_adv_o for exactly that cycle. page_adv_o is low at all other times.
- R11: Command FFh sets region_o to 0 and col_o to 0 and returns to idle.
- R12: Command bytes other than 00h, 01h, 50h and FFh (for example 80h or 60h) change neither col_o nor region_o.
- R13: spare_o is high exactly when col_o is in 512..527.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_vld_i | input | 1 | One-cycle pulse: cmd_i holds a latched command byte |
| cmd_i | input | 8 | Command byte |
| addr_vld_i | input | 1 | One-cycle pulse: addr_i holds a latched address byte |
| addr_i | input | 8 | Address byte |
| rd_stb_i | input | 1 | One-cycle read data strobe |
| wr_stb_i | input | 1 | One-cycle write data strobe |
| spare_dis_i | input | 1 | Static input; high blocks the spare region command |
| col_o | output | 10 | Current column, 0..527 |
| spare_o | output | 1 | Current column lies in the spare part |
| region_o | output | 2 | Region in force: 0 lower, 1 upper, 2 spare |
| page_adv_o | output | 1 | One-cycle pulse on a wrap past column 527 |

## Verification
A wrong region register shows at the ports in two ways. region_o is wrong on the edge right after the faulty command. The wrong base then shows up in col_o once the first address byte arrives. A wrong revert, or a wrong wrap base, can stay hidden until a page ends. For that reason the bench streams full pages of strobes through every region and samples col_o and page_adv_o after each one. A fault in the state machine, such as a column byte taken twice or a strobe taken in idle, shows in col_o one cycle after the offending pulse.

// File: rtl/nand_colptr_pkg.sv
package nand_colptr_pkg;

    typedef enum logic [1:0] {
        RGN_LOW   = 2'd0,
        RGN_HIGH  = 2'd1,
        RGN_SPARE = 2'd2
    } rgn_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COL,
        ST_ROW,
        ST_STREAM
    } st_e;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_LOW,
        EV_HIGH,
        EV_SPARE,
        EV_HOME
    } ev_e;

    localparam logic [7:0] OP_LOW   = 8'h00;
    localparam logic [7:0] OP_HIGH  = 8'h01;
    localparam logic [7:0] OP_SPARE = 8'h50;
    localparam logic [7:0] OP_HOME  = 8'hFF;

endpackage

// File: rtl/nand_colptr_cmd_dec.sv
module nand_colptr_cmd_dec
    import nand_colptr_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              cmd_vld,
    input  logic [BYTE_W-1:0] cmd,
    input  logic              spare_dis,
    output ev_e               ev
);

    always_comb begin
        ev = EV_NONE;
        if (cmd_vld) begin
            if (cmd == BYTE_W'(OP_LOW))
                ev = EV_LOW;
            else if (cmd == BYTE_W'(OP_HIGH))
                ev = EV_HIGH;
            else if (cmd == BYTE_W'(OP_SPARE) && !spare_dis)
                ev = EV_SPARE;
            else if (cmd == BYTE_W'(OP_HOME))
                ev = EV_HOME;
        end
    end

endmodule

// File: rtl/nand_colptr_ctr.sv
module nand_colptr_ctr #(
    parameter int COL_W    = 10,
    parameter int LAST_COL = 527
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [COL_W-1:0] load_val,
    input  logic             step,
    input  logic [COL_W-1:0] wrap_base,
    output logic [COL_W-1:0] col,
    output logic             adv
);

    localparam logic [COL_W-1:0] LAST = COL_W'(LAST_COL);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col <= '0;
            adv <= 1'b0;
        end else if (load) begin
            col <= load_val;
            adv <= 1'b0;
        end else if (step) begin
            if (col == LAST) begin
                col <= wrap_base;
                adv <= 1'b1;
            end else begin
                col <= col + 1'b1;
                adv <= 1'b0;
            end
        end else begin
            adv <= 1'b0;
        end
    end

endmodule

// File: rtl/nand_colptr.sv
module nand_colptr
    import nand_colptr_pkg::*;
#(
    parameter int MAIN_BYTES  = 512,
    parameter int SPARE_BYTES = 16,
    parameter int BYTE_W      = 8,
    localparam int PAGE_BYTES = MAIN_BYTES + SPARE_BYTES,
    localparam int COL_W      = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_vld_i,
    input  logic [BYTE_W-1:0] cmd_i,
    input  logic              addr_vld_i,
    input  logic [BYTE_W-1:0] addr_i,
    input  logic              rd_stb_i,
    input  logic              wr_stb_i,
    input  logic              spare_dis_i,
    output logic [COL_W-1:0]  col_o,
    output logic              spare_o,
    output logic [1:0]        region_o,
    output logic              page_adv_o
);

    localparam int HALF_BYTES = MAIN_BYTES / 2;
    localparam int HALF_W     = $clog2(HALF_BYTES);
    localparam int SPARE_W    = $clog2(SPARE_BYTES);
    localparam logic [COL_W-1:0] BASE_HIGH  = COL_W'(HALF_BYTES);
    localparam logic [COL_W-1:0] BASE_SPARE = COL_W'(MAIN_BYTES);

    st_e  state_q, state_d;
    rgn_e rgn_q, rgn_d;
    ev_e  ev;

    logic             ld;
    logic [COL_W-1:0] ld_val;
    logic             stp;
    logic [COL_W-1:0] wrap_base;
    logic [COL_W-1:0] col;
    logic             adv;
    logic             strobe;

    function automatic logic [COL_W-1:0] base_of(input rgn_e r);
        case (r)
            RGN_HIGH:  return BASE_HIGH;
            RGN_SPARE: return BASE_SPARE;
            default:   return '0;
        endcase
    endfunction

    nand_colptr_cmd_dec #(.BYTE_W(BYTE_W)) dec_i (
        .cmd_vld   (cmd_vld_i),
        .cmd       (cmd_i),
        .spare_dis (spare_dis_i),
        .ev        (ev)
    );

    nand_colptr_ctr #(.COL_W(COL_W), .LAST_COL(PAGE_BYTES - 1)) ctr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ld),
        .load_val  (ld_val),
        .step      (stp),
        .wrap_base (wrap_base),
        .col       (col),
        .adv       (adv)
    );

    assign strobe = rd_stb_i | wr_stb_i;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rgn_q   <= RGN_LOW;
        end else begin
            state_q <= state_d;
            rgn_q   <= rgn_d;
        end
    end

    // Next state and counter controls
    always_comb begin
        state_d   = state_q;
        rgn_d     = rgn_q;
        ld        = 1'b0;
        ld_val    = col;
        stp       = 1'b0;
        wrap_base = base_of(rgn_q);
        if (ev != EV_NONE) begin
            ld = 1'b1;
            unique case (ev)
                EV_LOW: begin
                    rgn_d   = RGN_LOW;
                    ld_val  = '0;
                    state_d = ST_COL;
                end
                EV_HIGH: begin
                    rgn_d   = RGN_HIGH;
                    ld_val  = BASE_HIGH;
                    state_d = ST_COL;
                end
                EV_SPARE: begin
                    rgn_d   = RGN_SPARE;
                    ld_val  = BASE_SPARE;
                    state_d = ST_COL;
                end
                default: begin
                    rgn_d   = RGN_LOW;
                    ld_val  = '0;
                    state_d = ST_IDLE;
                end
            endcase
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_COL: begin
                    if (addr_vld_i) begin
                        ld      = 1'b1;
                        state_d = ST_ROW;
                        if (rgn_q == RGN_SPARE)
                            ld_val = BASE_SPARE + COL_W'(addr_i[SPARE_W-1:0]);
                        else
                            ld_val = base_of(rgn_q) + COL_W'(addr_i[HALF_W-1:0]);
                    end else if (strobe) begin
                        stp     = 1'b1;
                        state_d = ST_STREAM;
                    end
                end
                ST_ROW, ST_STREAM: begin
                    if (strobe) begin
                        stp     = 1'b1;
                        state_d = ST_STREAM;
                    end
                end
            endcase
            if (stp && rgn_q == RGN_HIGH) begin
                rgn_d = RGN_LOW;
            end
            wrap_base = base_of(rgn_d);
        end
    end

    // Outputs
    always_comb begin
        col_o      = col;
        spare_o    = (col >= BASE_SPARE);
        region_o   = rgn_q;
        page_adv_o = adv;
    end

endmodule

// File: rtl/nand_colptr_chk.sv
module nand_colptr_chk #(
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_vld_i,
    input logic [7:0]       cmd_i,
    input logic             addr_vld_i,
    input logic             rd_stb_i,
    input logic             wr_stb_i,
    input logic             spare_dis_i,
    input logic [COL_W-1:0] col_o,
    input logic             spare_o,
    input logic [1:0]       region_o,
    input logic             page_adv_o
);

    a_r8_col_in_page: assert property (@(posedge clk) disable iff (!rst_n)
        col_o <= COL_W'(527));

    a_r4_spare_region_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        region_o == 2'd2 |-> col_o >= COL_W'(512));

    a_r13_spare_flag: assert property (@(posedge clk) disable iff (!rst_n)
        spare_o |-> region_o != 2'd1);

    a_r10_adv_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (!page_adv_o && !cmd_vld_i && (rd_stb_i || wr_stb_i) && col_o == COL_W'(527) && region_o != 2'd0)
        |=> page_adv_o && col_o == COL_W'(512));

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        page_adv_o |=> !page_adv_o);

    a_r9_high_reverts: assert property (@(posedge clk) disable iff (!rst_n)
        (region_o == 2'd1 && !cmd_vld_i && !addr_vld_i && (rd_stb_i || wr_stb_i))
        |=> region_o == 2'd0);

    a_r11_home: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld_i && cmd_i == 8'hFF) |=> (col_o == '0 && region_o == 2'd0));

    a_r5_spare_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld_i && cmd_i == 8'h50 && spare_dis_i && !addr_vld_i && !rd_stb_i && !wr_stb_i)
        |=> ($stable(col_o) && $stable(region_o)));

endmodule

bind nand_colptr nand_colptr_chk #(.COL_W(COL_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_vld_i   (cmd_vld_i),
    .cmd_i       (cmd_i),
    .addr_vld_i  (addr_vld_i),
    .rd_stb_i    (rd_stb_i),
    .wr_stb_i    (wr_stb_i),
    .spare_dis_i (spare_dis_i),
    .col_o       (col_o),
    .spare_o     (spare_o),
    .region_o    (region_o),
    .page_adv_o  (page_adv_o)
);

// File: tb/nand_colptr_tb_top.sv
module nand_colptr_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_vld_i = 1'b0;
    logic [7:0] cmd_i = 8'h00;
    logic       addr_vld_i = 1'b0;
    logic [7:0] addr_i = 8'h00;
    logic       rd_stb_i = 1'b0;
    logic       wr_stb_i = 1'b0;
    logic       spare_dis_i = 1'b0;
    logic [9:0] col_o;
    logic       spare_o;
    logic [1:0] region_o;
    logic       page_adv_o;

    int checks = 0;
    int errors = 0;
    int exp_col;
    int exp_rgn;
    bit done = 0;

    always #2 clk = ~clk;

    nand_colptr dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_vld_i   (cmd_vld_i),
        .cmd_i       (cmd_i),
        .addr_vld_i  (addr_vld_i),
        .addr_i      (addr_i),
        .rd_stb_i    (rd_stb_i),
        .wr_stb_i    (wr_stb_i),
        .spare_dis_i (spare_dis_i),
        .col_o       (col_o),
        .spare_o     (spare_o),
        .region_o    (region_o),
        .page_adv_o  (page_adv_o)
    );

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic check_all(input string tag, input int ecol, input int ergn, input int eadv);
        chk({tag, " col"}, int'(col_o), ecol);
        chk({tag, " region"}, int'(region_o), ergn);
        chk({tag, " page_adv"}, int'(page_adv_o), eadv);
        chk({tag, " R13 spare flag"}, int'(spare_o), (ecol >= 512) ? 1 : 0);
    endtask

    task automatic send_cmd(input logic [7:0] b);
        cmd_vld_i = 1'b1;
        cmd_i     = b;
        @(negedge clk);
        cmd_vld_i = 1'b0;
    endtask

    task automatic send_addr(input logic [7:0] b);
        addr_vld_i = 1'b1;
        addr_i     = b;
        @(negedge clk);
        addr_vld_i = 1'b0;
    endtask

    task automatic strobe(input bit use_rd);
        rd_stb_i = use_rd;
        wr_stb_i = !use_rd;
        @(negedge clk);
        rd_stb_i = 1'b0;
        wr_stb_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset", 0, 0, 0);

        // R8: strobes in idle are ignored; R7: address in idle ignored
        strobe(1);
        check_all("R8 idle strobe", 0, 0, 0);
        send_addr(8'h33);
        check_all("R7 idle addr", 0, 0, 0);

        // R2/R3/R4 region commands
        send_cmd(8'h01);
        check_all("R3 high cmd", 256, 1, 0);
        send_cmd(8'h00);
        check_all("R2 low cmd", 0, 0, 0);
        send_cmd(8'h50);
        check_all("R4 spare cmd", 512, 2, 0);

        // R6/R7 sweep of column bytes over every region
        for (int b = 0; b < 256; b++) begin
            send_cmd(8'h00);
            send_addr(8'(b));
            check_all("R6 low offset", b, 0, 0);
            send_addr(8'(~b));
            chk("R7 extra addr low", int'(col_o), b);
            send_cmd(8'h01);
            send_addr(8'(b));
            check_all("R6 high offset", 256 + b, 1, 0);
            send_cmd(8'h50);
            send_addr(8'(b));
            check_all("R6 spare offset", 512 + (b % 16), 2, 0);
        end

        // R8/R10 full page in the lower region, alternating rd and wr
        send_cmd(8'h00);
        send_addr(8'h00);
        exp_col = 0;
        for (int i = 1; i <= 528; i++) begin
            strobe(i % 2 == 0);
            exp_col = i % 528;
            check_all("R8 R10 low stream", exp_col, 0, (i == 528) ? 1 : 0);
        end
        strobe(1);
        check_all("R10 pulse once", 1, 0, 0);

        // R10 spare wrap back to 512
        send_cmd(8'h50);
        send_addr(8'hFE);
        check_all("R6 spare addr", 526, 2, 0);
        strobe(1);
        check_all("R8 spare step", 527, 2, 0);
        strobe(0);
        check_all("R10 spare wrap", 512, 2, 1);
        strobe(1);
        check_all("R10 spare after wrap", 513, 2, 0);

        // R9 upper half reverts after first strobe, wrap uses base 0
        send_cmd(8'h01);
        send_addr(8'd250);
        check_all("R6 high addr", 506, 1, 0);
        strobe(1);
        check_all("R9 revert", 507, 0, 0);
        exp_col = 507;
        for (int i = 0; i < 20; i++) begin
            strobe(1);
            exp_col++;
            check_all("R9 stream", exp_col, 0, 0);
        end
        strobe(1);
        check_all("R10 wrap after revert", 0, 0, 1);

        // R5 spare command blocked when disabled
        send_cmd(8'h00);
        send_addr(8'd7);
        spare_dis_i = 1'b1;
        @(negedge clk);
        send_cmd(8'h50);
        check_all("R5 blocked spare", 7, 0, 0);
        send_cmd(8'h01);
        send_addr(8'd3);
        send_cmd(8'h50);
        check_all("R5 blocked from high", 259, 1, 0);
        spare_dis_i = 1'b0;
        @(negedge clk);

        // R12 unrelated commands
        send_cmd(8'h80);
        check_all("R12 cmd 80h", 259, 1, 0);
        send_cmd(8'h60);
        check_all("R12 cmd 60h", 259, 1, 0);
        send_cmd(8'h90);
        check_all("R12 cmd 90h", 259, 1, 0);

        // R11 home command from spare with a streamed column
        send_cmd(8'h50);
        send_addr(8'h05);
        strobe(0);
        check_all("R8 spare stream", 518, 2, 0);
        send_cmd(8'hFF);
        check_all("R11 home", 0, 0, 0);
        strobe(1);
        check_all("R11 idle after home", 0, 0, 0);
        send_addr(8'h44);
        check_all("R7 addr after home", 0, 0, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule